// File: doc/BRIEF.md
# Shared-Adder Control-Flow Sequencer

This block owns the program counter of a small word-addressed processor core that has exactly one general adder (the ALU) and one fixed increment-by-one adder. Decoded control-flow requests arrive on a valid/ready port. Each request carries a kind, a signed immediate, a register operand value and a destination register index. The block sets the ALU operand selects, computes the next program counter and drives a one-cycle register-file write port for the link value.

A plain sequential step takes the increment adder's output. A relative jump and a register jump load the PC from the ALU sum. The next-PC mux therefore has only two inputs: the incrementer and the ALU. A jump-and-link needs two sums, the return address and the target, and both come from the single ALU over two cycles. In the accept cycle the ALU forms the return address, which is captured for write-back. In the following wait cycle the ALU forms the target, and the PC loads it. During the wait cycle `stall` is high and `req_ready` is low.

Back-pressure rules: a request is taken on a rising edge where both `req_valid` and `req_ready` are high. `req_ready` is low only during the wait cycle of a jump-and-link. A request that is offered then stays pending and has no effect until `req_ready` returns. When no request is taken, the PC holds. Additions wrap modulo 2^PC_W.

Top module: `branch_seq`

## Requirements
- R1: A synchronous reset sets `pc` to 0, clears `stall` and `rf_we`, and leaves `req_ready` high. This holds even when reset arrives in the middle of a jump-and-link.
- R2: A taken request of kind 0 (sequential step) sets `pc` to `pc`+1 on the next edge. With no taken request, `pc` holds.
- R3: A taken request of kind 1 (relative jump) sets `pc` to `pc`+1+sext(`req_imm`) on the next edge.
- R4: A taken request of kind 3 (register jump) sets `pc` to `req_rs`+sext(`req_imm`) on the next edge.
- R5: A taken request of kind 2 (jump-and-link) has the following effects in the next cycle: `stall`=1, `req_ready`=0, `rf_we`=1, `rf_waddr` equal to the taken `req_rd`, `rf_wdata` equal to the old `pc`+1, and `pc` unchanged.
- R6: One cycle after the wait cycle of R5, `pc` equals the old `pc`+1+sext(imm) of the taken request, and `stall` is 0. The wait cycle lasts exactly one cycle.
- R7: While `req_ready` is low, the request inputs have no effect. `pc` becomes only the jump-and-link target, and `rf_waddr` keeps the taken index even if `req_rd` changes.
- R8: `rf_we` is high for exactly one cycle per jump-and-link and is never high for any other kind.
- R9: Kinds 4 (jump-and-link via register, not built in hardware) and 5 to 7 raise `bad_op` combinationally in the cycle the request is taken. They advance `pc` by one and write no register.
- R10: All address sums wrap modulo 2^16, so 0xFFFF+1 gives 0.
- R11: The ALU selects are as follows. `alu_a_sel` uses 0=PC, 1=PC+1, 2=register operand. `alu_b_sel` uses 0=constant one, 1=immediate. The jump-and-link accept cycle uses (0,0), the wait cycle uses (1,1), a register jump uses (2,1) and a relative jump uses (1,1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken (low in the wait cycle) |
| req_op | input | 3 | Request kind: 0 step, 1 relative jump, 2 jump-and-link, 3 register jump, 4..7 illegal |
| req_imm | input | IMM_W | Signed immediate |
| req_rs | input | PC_W | Register operand value |
| req_rd | input | RD_W | Link destination index |
| pc | output | PC_W | Current program counter |
| next_pc | output | PC_W | Two-input mux output: incrementer or ALU |
| stall | output | 1 | Fetch hold during the wait cycle |
| bad_op | output | 1 | Illegal kind taken this cycle |
| alu_a_sel | output | 2 | ALU operand A select |
| alu_b_sel | output | 1 | ALU operand B select |
| rf_we | output | 1 | Link write enable |
| rf_waddr | output | RD_W | Link write index |
| rf_wdata | output | PC_W | Link value |

## Verification
In the wait cycle of a jump-and-link, two things happen together. The link write-back is presented on the register port, and the ALU is reused to form the jump target that the PC loads at the end of that cycle. At the same time a new request can be offered. The bench provokes this by keeping `req_valid` high through the wait cycle with a different kind and a different `req_rd`. It then judges that the write port still shows the taken index and return address, and that the PC lands on the jump target and not on anything the new request would produce.

// File: rtl/branch_seq_pkg.sv
package branch_seq_pkg;
  localparam logic [2:0] OP_SEQ = 3'd0;
  localparam logic [2:0] OP_JMP = 3'd1;
  localparam logic [2:0] OP_JAL = 3'd2;
  localparam logic [2:0] OP_JR  = 3'd3;

  typedef enum logic [1:0] {A_PC = 2'd0, A_INC = 2'd1, A_REG = 2'd2} asel_e;
  typedef enum logic {B_ONE = 1'b0, B_IMM = 1'b1} bsel_e;
  typedef enum logic {ST_EXEC = 1'b0, ST_LINK2 = 1'b1} state_e;
endpackage

// File: rtl/bs_alu.sv
module bs_alu import branch_seq_pkg::*; #(
  parameter int PC_W  = 16,
  parameter int IMM_W = 16
) (
  input  asel_e             asel,
  input  bsel_e             bsel,
  input  logic [PC_W-1:0]   pc,
  input  logic [PC_W-1:0]   inc,
  input  logic [PC_W-1:0]   rs,
  input  logic [IMM_W-1:0]  imm,
  output logic [PC_W-1:0]   y
);
  logic [PC_W-1:0] imm_x, op_a, op_b;

  generate
    if (IMM_W < PC_W) begin : g_sext
      assign imm_x = {{(PC_W-IMM_W){imm[IMM_W-1]}}, imm};
    end else begin : g_trunc
      assign imm_x = imm[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    case (asel)
      A_PC:    op_a = pc;
      A_INC:   op_a = inc;
      default: op_a = rs;
    endcase
    op_b = (bsel == B_IMM) ? imm_x : PC_W'(1);
    y = op_a + op_b;
  end
endmodule

// File: rtl/bs_ctrl.sv
module bs_ctrl import branch_seq_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [2:0] req_op,
  output logic       req_ready,
  output logic       in_link2,
  output asel_e      asel,
  output bsel_e      bsel,
  output logic       pc_load,
  output logic       npc_from_alu,
  output logic       link_cap,
  output logic       bad_op
);
  state_e state;
  logic   take;

  assign in_link2  = (state == ST_LINK2);
  assign req_ready = !in_link2;
  assign take      = req_valid && req_ready;

  always_comb begin
    asel         = A_PC;
    bsel         = B_ONE;
    pc_load      = 1'b0;
    npc_from_alu = 1'b0;
    link_cap     = 1'b0;
    bad_op       = 1'b0;
    if (in_link2) begin
      asel = A_INC; bsel = B_IMM; pc_load = 1'b1; npc_from_alu = 1'b1;
    end else if (take) begin
      case (req_op)
        OP_SEQ: pc_load = 1'b1;
        OP_JMP: begin asel = A_INC; bsel = B_IMM; pc_load = 1'b1; npc_from_alu = 1'b1; end
        OP_JR:  begin asel = A_REG; bsel = B_IMM; pc_load = 1'b1; npc_from_alu = 1'b1; end
        OP_JAL: link_cap = 1'b1;
        default: begin bad_op = 1'b1; pc_load = 1'b1; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              state <= ST_EXEC;
    else if (in_link2)    state <= ST_EXEC;
    else if (link_cap)    state <= ST_LINK2;
  end
endmodule

// File: rtl/bs_link.sv
module bs_link #(
  parameter int PC_W  = 16,
  parameter int IMM_W = 16,
  parameter int RD_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap,
  input  logic [RD_W-1:0]  rd_in,
  input  logic [IMM_W-1:0] imm_in,
  input  logic [PC_W-1:0]  link_val,
  output logic             we,
  output logic [RD_W-1:0]  waddr,
  output logic [PC_W-1:0]  wdata,
  output logic [IMM_W-1:0] imm_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      we    <= 1'b0;
      waddr <= '0;
      wdata <= '0;
      imm_q <= '0;
    end else begin
      we <= cap;
      if (cap) begin
        waddr <= rd_in;
        wdata <= link_val;
        imm_q <= imm_in;
      end
    end
  end
endmodule

// File: rtl/branch_seq.sv
module branch_seq import branch_seq_pkg::*; #(
  parameter int PC_W  = 16,
  parameter int IMM_W = 16,
  parameter int RD_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [IMM_W-1:0] req_imm,
  input  logic [PC_W-1:0]  req_rs,
  input  logic [RD_W-1:0]  req_rd,
  output logic [PC_W-1:0]  pc,
  output logic [PC_W-1:0]  next_pc,
  output logic             stall,
  output logic             bad_op,
  output logic [1:0]       alu_a_sel,
  output logic             alu_b_sel,
  output logic             rf_we,
  output logic [RD_W-1:0]  rf_waddr,
  output logic [PC_W-1:0]  rf_wdata
);
  asel_e            asel;
  bsel_e            bsel;
  logic             pc_load, npc_from_alu, link_cap, in_link2;
  logic [PC_W-1:0]  inc, alu_y;
  logic [IMM_W-1:0] imm_q, imm_use;

  bs_ctrl u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_ready(req_ready), .in_link2(in_link2), .asel(asel), .bsel(bsel),
    .pc_load(pc_load), .npc_from_alu(npc_from_alu), .link_cap(link_cap),
    .bad_op(bad_op)
  );

  assign inc     = pc + PC_W'(1);
  assign imm_use = in_link2 ? imm_q : req_imm;

  bs_alu #(.PC_W(PC_W), .IMM_W(IMM_W)) u_alu (
    .asel(asel), .bsel(bsel), .pc(pc), .inc(inc), .rs(req_rs),
    .imm(imm_use), .y(alu_y)
  );

  bs_link #(.PC_W(PC_W), .IMM_W(IMM_W), .RD_W(RD_W)) u_link (
    .clk(clk), .rst(rst), .cap(link_cap), .rd_in(req_rd), .imm_in(req_imm),
    .link_val(alu_y), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .imm_q(imm_q)
  );

  assign next_pc   = npc_from_alu ? alu_y : inc;
  assign stall     = in_link2;
  assign alu_a_sel = asel;
  assign alu_b_sel = bsel;

  always_ff @(posedge clk) begin
    if (rst)          pc <= '0;
    else if (pc_load) pc <= next_pc;
  end
endmodule

// File: rtl/branch_seq_chk.sv
module branch_seq_chk #(
  parameter int PC_W = 16,
  parameter int RD_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic [2:0]      req_op,
  input logic [RD_W-1:0] req_rd,
  input logic [PC_W-1:0] pc,
  input logic            stall,
  input logic            bad_op,
  input logic            rf_we,
  input logic [RD_W-1:0] rf_waddr,
  input logic [PC_W-1:0] rf_wdata
);
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (pc == '0 && !stall && !rf_we));

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_op == 3'd0) |=> (pc == $past(pc) + PC_W'(1)));

  assert_link_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_op == 3'd2) |=>
      (rf_we && stall && $stable(pc) && rf_waddr == $past(req_rd)
       && rf_wdata == $past(pc) + PC_W'(1)));

  assert_wait_one_R6: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall);

  assert_single_write_R8: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> !rf_we);

  assert_bad_taken_R9: assert property (@(posedge clk) disable iff (rst)
    bad_op |-> (req_valid && req_ready && req_op >= 3'd4));
endmodule

bind branch_seq branch_seq_chk #(.PC_W(PC_W), .RD_W(RD_W)) u_chk (.*);

// File: tb/branch_seq_test.sv
module branch_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [15:0] req_imm = '0, req_rs = '0;
  logic [3:0]  req_rd = '0;
  logic [15:0] pc, next_pc, rf_wdata;
  logic        stall, bad_op, alu_b_sel, rf_we;
  logic [1:0]  alu_a_sel;
  logic [3:0]  rf_waddr;

  int nchecks = 0, nerr = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  branch_seq uut (.*);

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] imm;
    logic [15:0] rs;
    logic [3:0]  rd;
    logic [15:0] exp_pc;
    logic [15:0] exp_link;
    logic        exp_bad;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{3'd0, 16'h0000, 16'h0000, 4'd0, 16'h0001, 16'h0000, 1'b0},
    '{3'd1, 16'h0005, 16'h0000, 4'd0, 16'h0007, 16'h0000, 1'b0},
    '{3'd3, 16'h0004, 16'h0100, 4'd0, 16'h0104, 16'h0000, 1'b0},
    '{3'd1, 16'hFFFE, 16'h0000, 4'd0, 16'h0103, 16'h0000, 1'b0},
    '{3'd2, 16'h0010, 16'h0000, 4'd3, 16'h0114, 16'h0104, 1'b0},
    '{3'd0, 16'h0000, 16'h0000, 4'd0, 16'h0115, 16'h0000, 1'b0},
    '{3'd3, 16'h0002, 16'hFFFF, 4'd0, 16'h0001, 16'h0000, 1'b0},
    '{3'd4, 16'h0033, 16'h0044, 4'd5, 16'h0002, 16'h0000, 1'b1},
    '{3'd2, 16'hFFF0, 16'h0000, 4'd7, 16'hFFF3, 16'h0003, 1'b0},
    '{3'd1, 16'h000B, 16'h0000, 4'd0, 16'hFFFF, 16'h0000, 1'b0},
    '{3'd0, 16'h0000, 16'h0000, 4'd0, 16'h0000, 16'h0000, 1'b0},
    '{3'd7, 16'h0000, 16'h0000, 4'd2, 16'h0001, 16'h0000, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic offer(input logic [2:0] op, input logic [15:0] imm,
                       input logic [15:0] rs, input logic [3:0] rd);
    req_op = op; req_imm = imm; req_rs = rs; req_rd = rd; req_valid = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nerr++; nchecks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchecks);
      $finish;
    end
  end

  initial begin
    logic [15:0] cur;
    repeat (2) @(negedge clk);
    chk("R1 pc", pc, 0);
    chk("R1 stall", stall, 0);
    chk("R1 ready", req_ready, 1);
    chk("R1 rf_we", rf_we, 0);
    rst = 1'b0;
    cur = 16'h0000;

    for (int i = 0; i < 12; i++) begin
      offer(VECS[i].op, VECS[i].imm, VECS[i].rs, VECS[i].rd);
      #1;
      chk("R9 bad_op", bad_op, VECS[i].exp_bad);
      chk("R7 ready before take", req_ready, 1);
      if (VECS[i].op == 3'd2) begin
        chk("R11 jal accept a", alu_a_sel, 0);
        chk("R11 jal accept b", alu_b_sel, 0);
      end
      if (VECS[i].op == 3'd3) begin
        chk("R11 jr a", alu_a_sel, 2);
        chk("R11 jr b", alu_b_sel, 1);
      end
      if (VECS[i].op == 3'd1) chk("R11 jmp a", alu_a_sel, 1);
      @(negedge clk);
      if (VECS[i].op == 3'd2) begin
        chk("R5 stall", stall, 1);
        chk("R5 ready low", req_ready, 0);
        chk("R5 rf_we", rf_we, 1);
        chk("R5 waddr", rf_waddr, VECS[i].rd);
        chk("R5 wdata", rf_wdata, VECS[i].exp_link);
        chk("R5 pc held", pc, cur);
        chk("R11 wait a", alu_a_sel, 1);
        chk("R11 wait b", alu_b_sel, 1);
        // R7: a different request is offered during the wait cycle
        offer(3'd3, 16'h1234, 16'h4321, ~VECS[i].rd);
        #1;
        chk("R7 waddr latched", rf_waddr, VECS[i].rd);
        @(negedge clk);
        chk("R6 target", pc, VECS[i].exp_pc);
        chk("R6 stall cleared", stall, 0);
        chk("R8 we one cycle", rf_we, 0);
      end else begin
        chk(VECS[i].op == 3'd0 ? "R2 step" : VECS[i].op == 3'd1 ? "R3 rel" :
            VECS[i].op == 3'd3 ? "R4 reg" : "R9 illegal step", pc, VECS[i].exp_pc);
        chk("R8 no write", rf_we, 0);
      end
      req_valid = 1'b0;
      cur = VECS[i].exp_pc;
    end

    // R2: no request, pc holds
    repeat (3) @(negedge clk);
    chk("R2 idle hold", pc, cur);

    // R10: wrap in relative and register forms
    offer(3'd1, 16'hFFFF, 16'h0000, 4'd0);
    @(negedge clk);
    chk("R10 rel wrap", pc, cur);
    offer(3'd3, 16'h0020, 16'hFFF0, 4'd0);
    @(negedge clk);
    chk("R10 reg wrap", pc, 16'h0010);
    req_valid = 1'b0;

    // R1: reset during the wait cycle
    offer(3'd2, 16'h0100, 16'h0000, 4'd9);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R5 stall before reset", stall, 1);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid pc", pc, 0);
    chk("R1 mid stall", stall, 0);
    chk("R1 mid rf_we", rf_we, 0);
    chk("R1 mid ready", req_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 stays idle", pc, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end
endmodule